// File: doc/BRIEF.md
# Real-Mode Segmented Address Generator

This block turns a segment:offset memory reference into a 20-bit physical address. It keeps four 16-bit segment registers (code, data, extra, stack). For each request it picks one of them from the kind of access and the register that supplies the offset. An explicit segment override can replace that choice where the access kind allows it. The physical address is the chosen segment shifted left by four bits plus the 16-bit offset. Any carry out of bit 19 is dropped, so the address wraps inside 1 MB.

Requests arrive on a valid/ready stream and results leave on a second valid/ready stream through a single output register. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. Its result is presented from the next cycle and is held until `rsp_ready` is seen high with `rsp_valid`. The input side stalls exactly when a result is waiting and the consumer is not taking it this cycle.

An offset wider than 16 bits is not used: it raises an illegal flag on the result. Segment registers are written through a plain write port. A request accepted in the same cycle as a write to its segment uses the newly written value.

Top module: `seg_addr_gen`

## Requirements
- R1: For an accepted request, the result is (segment << 4) + offset[15:0], taken modulo 2^20. It appears on `rsp_addr` with `rsp_valid` high in the cycle after acceptance.
- R2: Access kind 0 (instruction fetch) always uses the code segment (index 0). Any override is ignored for this kind.
- R3: Access kind 1 (stack) uses the stack segment (index 3). Access kind 2 (data) also uses the stack segment when the base tag is 3 (frame base pointer) or 4 (stack pointer).
- R4: Access kind 2 (data) with any other base tag uses the data segment (index 1). The other tags are 0 base index, 1 source index, 2 destination index, 5 literal displacement, 6 instruction pointer and 7 spare.
- R5: Access kind 3 (string destination) always uses the extra segment (index 2). Any override is ignored for this kind.
- R6: For kinds 1 and 2, when `ovr_valid` is high, the segment indexed by `ovr_seg` replaces the default. The indices are 0 code, 1 data, 2 extra, 3 stack.
- R7: If any bit of `req_offset` above bit 15 is set, `rsp_illegal` is 1 and `rsp_addr` is 0. Otherwise `rsp_illegal` is 0.
- R8: When `seg_we` is high at a clock edge, the segment indexed by `seg_wsel` takes `seg_wdata`. A request accepted at the same edge that selects this segment uses `seg_wdata`.
- R9: After reset all four segments are 0, `rsp_valid` is 0 and `req_ready` is 1.
- R10: `req_ready` equals (not `rsp_valid`) or `rsp_ready`. While `rsp_valid` is high and `rsp_ready` is low, the result stays valid and unchanged in the next cycle.
- R11: Distinct segment:offset pairs that name the same location give the same address. For example, 07A0:0100 and 07B0:0000 both give 07B00h, and FFFF:0010 wraps to 00000h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_kind | input | 2 | Access kind: 0 fetch, 1 stack, 2 data, 3 string destination |
| req_base | input | 3 | Tag of the register supplying the offset |
| req_offset | input | 32 | Offset value; only values up to FFFFh are legal |
| ovr_valid | input | 1 | Explicit segment override present |
| ovr_seg | input | 2 | Overriding segment index |
| seg_we | input | 1 | Segment register write enable |
| seg_wsel | input | 2 | Segment register to write |
| seg_wdata | input | 16 | Value to write |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_addr | output | 20 | Physical address |
| rsp_illegal | output | 1 | Offset was out of range |

## Verification
Two events can fall in the same cycle: a segment register write and the acceptance of a request that selects that same register. The bench provokes this on purpose in directed cases and also lets it happen often in the random phase, where writes and requests are issued independently. The expected address is always formed from the value being written, not from the old contents. A second overlap is a result being drained while a new request is accepted under random back-pressure. It is judged by comparing every delivered result, in order, against a queue of expected results.

// File: rtl/seg_addr_pkg.sv
package seg_addr_pkg;
  localparam int SEG_W    = 16;
  localparam int OFS_W    = 16;
  localparam int ADDR_W   = 20;
  localparam int NSEG     = 4;
  localparam int SEL_W    = $clog2(NSEG);

  typedef enum logic [1:0] {
    KIND_FETCH  = 2'd0,
    KIND_STACK  = 2'd1,
    KIND_DATA   = 2'd2,
    KIND_STRDST = 2'd3
  } acc_kind_e;

  typedef enum logic [2:0] {
    BASE_BX   = 3'd0,
    BASE_SI   = 3'd1,
    BASE_DI   = 3'd2,
    BASE_BP   = 3'd3,
    BASE_SP   = 3'd4,
    BASE_DISP = 3'd5,
    BASE_IP   = 3'd6,
    BASE_RSV  = 3'd7
  } base_tag_e;

  typedef enum logic [1:0] {
    SEG_CODE  = 2'd0,
    SEG_DATA  = 2'd1,
    SEG_EXTRA = 2'd2,
    SEG_STACK = 2'd3
  } seg_idx_e;

  typedef struct packed {
    logic              illegal;
    logic [ADDR_W-1:0] addr;
  } rsp_t;
endpackage

// File: rtl/seg_regfile.sv
module seg_regfile
  import seg_addr_pkg::*;
#(
  parameter int N  = NSEG,
  parameter int W  = SEG_W,
  localparam int SW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [SW-1:0] wsel,
  input  logic [W-1:0]  wdata,
  input  logic [SW-1:0] rsel,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] regs [N];

  for (genvar g = 0; g < N; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n)
        regs[g] <= '0;
      else if (we && (wsel == SW'(g)))
        regs[g] <= wdata;
    end
  end

  // forward a write in flight to a reader of the same register
  always_comb begin
    if (we && (wsel == rsel))
      rdata = wdata;
    else
      rdata = regs[rsel];
  end

  // R8
  write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (regs[$past(wsel)] == $past(wdata)));
endmodule

// File: rtl/seg_select.sv
module seg_select
  import seg_addr_pkg::*;
(
  input  logic [1:0] kind,
  input  logic [2:0] base,
  input  logic       ovr_valid,
  input  logic [1:0] ovr_seg,
  output logic [1:0] sel
);
  logic [1:0] dflt;
  logic       ovr_ok;

  always_comb begin
    unique case (acc_kind_e'(kind))
      KIND_FETCH:  dflt = SEG_CODE;
      KIND_STACK:  dflt = SEG_STACK;
      KIND_STRDST: dflt = SEG_EXTRA;
      default: begin
        if (base == BASE_BP || base == BASE_SP)
          dflt = SEG_STACK;
        else
          dflt = SEG_DATA;
      end
    endcase
  end

  assign ovr_ok = ovr_valid && (kind == KIND_STACK || kind == KIND_DATA);
  assign sel    = ovr_ok ? ovr_seg : dflt;
endmodule

// File: rtl/seg_addr_adder.sv
module seg_addr_adder
  import seg_addr_pkg::*;
#(
  parameter int IN_W = 32,
  parameter int SW   = SEG_W,
  parameter int OW   = OFS_W,
  parameter int AW   = ADDR_W,
  localparam int SH  = AW - SW
) (
  input  logic [SW-1:0]   seg,
  input  logic [IN_W-1:0] offset,
  output logic [AW-1:0]   addr,
  output logic            illegal
);
  logic [AW-1:0] seg_sh;
  logic [AW-1:0] ofs_ext;
  logic [AW-1:0] sum;

  assign seg_sh  = {seg, {SH{1'b0}}};
  assign ofs_ext = {{(AW-OW){1'b0}}, offset[OW-1:0]};
  assign sum     = seg_sh + ofs_ext;

  if (IN_W > OW) begin : g_wide
    assign illegal = |offset[IN_W-1:OW];
  end else begin : g_narrow
    assign illegal = 1'b0;
  end

  assign addr = illegal ? '0 : sum;
endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
  import seg_addr_pkg::*;
#(
  parameter int OFS_IN_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [1:0]          req_kind,
  input  logic [2:0]          req_base,
  input  logic [OFS_IN_W-1:0] req_offset,
  input  logic                ovr_valid,
  input  logic [1:0]          ovr_seg,
  input  logic                seg_we,
  input  logic [1:0]          seg_wsel,
  input  logic [SEG_W-1:0]    seg_wdata,
  output logic                rsp_valid,
  input  logic                rsp_ready,
  output logic [ADDR_W-1:0]   rsp_addr,
  output logic                rsp_illegal
);
  logic [1:0]        sel;
  logic [SEG_W-1:0]  seg_val;
  logic [ADDR_W-1:0] addr_nx;
  logic              ill_nx;
  logic              take;
  rsp_t              out_q;
  logic              vld_q;

  seg_select u_sel (
    .kind      (req_kind),
    .base      (req_base),
    .ovr_valid (ovr_valid),
    .ovr_seg   (ovr_seg),
    .sel       (sel)
  );

  seg_regfile #(.N(NSEG), .W(SEG_W)) u_rf (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (seg_we),
    .wsel  (seg_wsel),
    .wdata (seg_wdata),
    .rsel  (sel),
    .rdata (seg_val)
  );

  seg_addr_adder #(.IN_W(OFS_IN_W), .SW(SEG_W), .OW(OFS_W), .AW(ADDR_W)) u_add (
    .seg     (seg_val),
    .offset  (req_offset),
    .addr    (addr_nx),
    .illegal (ill_nx)
  );

  assign req_ready = !vld_q || rsp_ready;
  assign take      = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      out_q <= '0;
    end else begin
      if (take) begin
        vld_q         <= 1'b1;
        out_q.addr    <= addr_nx;
        out_q.illegal <= ill_nx;
      end else if (rsp_ready) begin
        vld_q <= 1'b0;
      end
    end
  end

  assign rsp_valid   = vld_q;
  assign rsp_addr    = out_q.addr;
  assign rsp_illegal = out_q.illegal;

  // R10
  hold_under_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_addr) && $stable(rsp_illegal)));

  // R10
  ready_when_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> req_ready);

  // R1
  accept_gives_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid);

  // R7
  illegal_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_illegal) |-> (rsp_addr == '0));

  // R2
  fetch_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_kind == KIND_FETCH) |-> (sel == SEG_CODE));

  // R5
  strdst_extra_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_kind == KIND_STRDST) |-> (sel == SEG_EXTRA));
endmodule

// File: tb/seg_addr_gen_tb_top.sv
module seg_addr_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic [1:0]  req_kind;
  logic [2:0]  req_base;
  logic [31:0] req_offset;
  logic        ovr_valid;
  logic [1:0]  ovr_seg;
  logic        seg_we;
  logic [1:0]  seg_wsel;
  logic [15:0] seg_wdata;
  logic        rsp_valid;
  logic        rsp_ready;
  logic [19:0] rsp_addr;
  logic        rsp_illegal;

  int n_tests = 0;
  int n_fail  = 0;
  logic [15:0] mseg [4];
  logic [20:0] expq [$];
  bit          done = 1'b0;

  always #10 clk = ~clk;

  seg_addr_gen dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_base(req_base), .req_offset(req_offset),
    .ovr_valid(ovr_valid), .ovr_seg(ovr_seg), .seg_we(seg_we),
    .seg_wsel(seg_wsel), .seg_wdata(seg_wdata), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_addr(rsp_addr), .rsp_illegal(rsp_illegal)
  );

  function automatic logic [1:0] exp_sel(input logic [1:0] k, input logic [2:0] b,
                                         input logic ov, input logic [1:0] os);
    if (k == 2'd0) return 2'd0;
    if (k == 2'd3) return 2'd2;
    if (ov) return os;
    if (k == 2'd1) return 2'd3;
    if (b == 3'd3 || b == 3'd4) return 2'd3;
    return 2'd1;
  endfunction

  function automatic logic [20:0] exp_rsp(input logic [15:0] s, input logic [31:0] o);
    logic [19:0] a;
    if (o[31:16] != 16'd0) return {1'b1, 20'd0};
    a = {s, 4'd0} + {4'd0, o[15:0]};
    return {1'b0, a};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one cycle: inputs set at negedge, handshake results tallied before the next edge
  task automatic cycle(input logic rv, input logic [1:0] k, input logic [2:0] b,
                       input logic [31:0] o, input logic ov, input logic [1:0] os,
                       input logic we, input logic [1:0] ws, input logic [15:0] wd,
                       input logic rr, input string tag);
    logic [1:0]  s;
    logic [15:0] sv;
    logic [20:0] e;
    @(negedge clk);
    req_valid = rv; req_kind = k; req_base = b; req_offset = o;
    ovr_valid = ov; ovr_seg = os; seg_we = we; seg_wsel = ws; seg_wdata = wd;
    rsp_ready = rr;
    #1;
    check({tag, " R10 ready"}, {31'd0, req_ready}, {31'd0, (!rsp_valid) || rr});
    if (rsp_valid) begin
      if (expq.size() == 0) check({tag, " R1 spurious"}, 32'd1, 32'd0);
      else begin
        e = expq[0];
        check({tag, " R1/R7 result"}, {11'd0, rsp_illegal, rsp_addr}, {11'd0, e});
        if (rr) void'(expq.pop_front());
      end
    end
    if (rv && req_ready) begin
      s  = exp_sel(k, b, ov, os);
      sv = (we && ws == s) ? wd : mseg[s];
      expq.push_back(exp_rsp(sv, o));
    end
    if (we) mseg[ws] = wd;
  endtask

  task automatic idle_drain();
    for (int i = 0; i < 3; i++)
      cycle(1'b0, 2'd0, 3'd0, 32'd0, 1'b0, 2'd0, 1'b0, 2'd0, 16'd0, 1'b1, "drain");
  endtask

  task automatic wr(input logic [1:0] ws, input logic [15:0] wd);
    cycle(1'b0, 2'd0, 3'd0, 32'd0, 1'b0, 2'd0, 1'b1, ws, wd, 1'b1, "write");
  endtask

  initial begin
    int unsigned seed;
    seed = 32'd20240611;
    void'($urandom(seed));
    for (int i = 0; i < 4; i++) mseg[i] = 16'd0;
    rst_n = 1'b0; req_valid = 1'b0; req_kind = 2'd0; req_base = 3'd0;
    req_offset = 32'd0; ovr_valid = 1'b0; ovr_seg = 2'd0; seg_we = 1'b0;
    seg_wsel = 2'd0; seg_wdata = 16'd0; rsp_ready = 1'b0;
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9 rsp_valid", {31'd0, rsp_valid}, 32'd0);
    check("R9 req_ready", {31'd0, req_ready}, 32'd1);
    rst_n = 1'b1;
    // R9 segments zero: fetch 1234 -> 01234
    cycle(1'b1, 2'd0, 3'd6, 32'h1234, 1'b0, 2'd0, 1'b0, 2'd0, 16'd0, 1'b1, "R9 zero seg");
    idle_drain();
    wr(2'd0, 16'h1000); wr(2'd1, 16'h2000); wr(2'd2, 16'h3000); wr(2'd3, 16'h4000);
    // R2 fetch ignores override
    cycle(1'b1, 2'd0, 3'd6, 32'h0010, 1'b1, 2'd3, 1'b0, 2'd0, 16'd0, 1'b1, "R2");
    // R3 stack, data via BP and SP
    cycle(1'b1, 2'd1, 3'd4, 32'h0020, 1'b0, 2'd0, 1'b0, 2'd0, 16'd0, 1'b1, "R3 stack");
    cycle(1'b1, 2'd2, 3'd3, 32'h0030, 1'b0, 2'd0, 1'b0, 2'd0, 16'd0, 1'b1, "R3 bp");
    // R4 data via BX
    cycle(1'b1, 2'd2, 3'd0, 32'h0040, 1'b0, 2'd0, 1'b0, 2'd0, 16'd0, 1'b1, "R4");
    // R5 string destination ignores override
    cycle(1'b1, 2'd3, 3'd2, 32'h0050, 1'b1, 2'd1, 1'b0, 2'd0, 16'd0, 1'b1, "R5");
    // R6 override on data
    cycle(1'b1, 2'd2, 3'd1, 32'h0060, 1'b1, 2'd2, 1'b0, 2'd0, 16'd0, 1'b1, "R6");
    // R7 illegal offset
    cycle(1'b1, 2'd2, 3'd5, 32'h0001_0000, 1'b0, 2'd0, 1'b0, 2'd0, 16'd0, 1'b1, "R7");
    // R8 same-cycle write and request on data segment
    cycle(1'b1, 2'd2, 3'd0, 32'h0005, 1'b0, 2'd0, 1'b1, 2'd1, 16'h5550, 1'b1, "R8 bypass");
    idle_drain();
    // R11 aliasing and wrap
    wr(2'd1, 16'h07A0); wr(2'd2, 16'h07B0); wr(2'd3, 16'hFFFF);
    cycle(1'b1, 2'd2, 3'd5, 32'h0100, 1'b0, 2'd0, 1'b0, 2'd0, 16'd0, 1'b1, "R11 alias a");
    idle_drain();
    check("R11 alias a", {12'd0, rsp_addr}, 32'h07B00);
    cycle(1'b1, 2'd3, 3'd2, 32'h0000, 1'b0, 2'd0, 1'b0, 2'd0, 16'd0, 1'b1, "R11 alias b");
    idle_drain();
    check("R11 alias b", {12'd0, rsp_addr}, 32'h07B00);
    cycle(1'b1, 2'd1, 3'd4, 32'h0010, 1'b0, 2'd0, 1'b0, 2'd0, 16'd0, 1'b1, "R11 wrap");
    idle_drain();
    check("R11 wrap", {12'd0, rsp_addr}, 32'h00000);
    // R10 stall: hold the result three cycles
    cycle(1'b1, 2'd1, 3'd4, 32'h0123, 1'b0, 2'd0, 1'b0, 2'd0, 16'd0, 1'b0, "R10 stall");
    for (int i = 0; i < 3; i++)
      cycle(1'b1, 2'd2, 3'd0, 32'h0777, 1'b0, 2'd0, 1'b0, 2'd0, 16'd0, 1'b0, "R10 stall");
    idle_drain();
    // random phase
    for (int i = 0; i < 1500; i++) begin
      logic [31:0] o;
      o = ($urandom % 8 == 0) ? $urandom : {16'd0, 16'($urandom)};
      cycle($urandom % 4 != 0, 2'($urandom), 3'($urandom), o,
            $urandom % 3 == 0, 2'($urandom), $urandom % 3 == 0, 2'($urandom),
            16'($urandom), $urandom % 3 != 0, "R1 random");
    end
    idle_drain();
    check("R1 queue empty", expq.size(), 32'd0);
    done = 1'b1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (100000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog R1 actual=timeout expected=finish");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule